// File: doc/BRIEF.md
# Ones' Complement End-Around-Carry Adder

This block adds two N-bit ones' complement operands. The carry out of the most significant bit goes back into the least significant bit, so the sum is the arithmetic sum reduced modulo 2^N − 1. In this number system zero has two encodings: all bits 0 (positive zero) and all bits 1 (negative zero). When the two operands are exact bitwise complements, every bit position propagates. The returned carry then has two consistent values, and a plain feedback wire could oscillate between them.

The adder never routes the sum or the carry out back into the carry chain. It computes the group generate and group propagate terms of the operands with carry-in 0 and derives the returned carry from those alone. In the all-propagate case a two-bit policy input decides which zero comes out. Two flags report whether the result is a zero and whether that zero is the negative one. A parameter adds an optional output register stage with asynchronous active-low reset.

Top module: `oca_adder`

## Requirements
- R1: For operands whose plain binary sum is below 2^N − 1, the sum equals that plain binary sum. No carry is returned.
- R2: When the plain binary sum of the operands exceeds 2^N − 1, the carry out of the top bit is added back at bit 0. The result equals the plain sum minus (2^N − 1). For example, at N=4, 1000 + 1000 gives 0001, and 1111 + 1111 gives 1111.
- R3: When the operands are bitwise complements of each other and the policy input is 2'b00 (force-one), the sum is positive zero (all 0s).
- R4: When the operands are bitwise complements of each other and the policy input is 2'b01 (force-zero), the sum is negative zero (all 1s).
- R5: Policy codes 2'b10 and 2'b11 give the same results as 2'b00 for every operand pair.
- R6: Two positive-zero operands give positive zero, and two negative-zero operands give negative zero, under every policy code.
- R7: `is_zero` is 1 exactly when the sum is all 0s or all 1s.
- R8: `is_negzero` is 1 exactly when the sum is all 1s.
- R9: With REG_OUT=1, the outputs show the result of the inputs present at the previous rising clock edge. With REG_OUT=0, the outputs follow the inputs combinationally.
- R10: With REG_OUT=1 and `rst_n` low, the outputs hold sum = all 0s, `is_zero` = 1 and `is_negzero` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| a | input | N | First ones' complement operand |
| b | input | N | Second ones' complement operand |
| zpol | input | 2 | Zero policy: 00 force-one, 01 force-zero, 10/11 treated as 00 |
| sum | output | N | Ones' complement sum |
| is_zero | output | 1 | Sum is positive or negative zero |
| is_negzero | output | 1 | Sum is negative zero |

## Verification
At width 4, every operand pair is applied under all four policy codes, and each result is compared against an integer model reduced modulo 15. Pairs with a plain sum below 15 exercise the path with no returned carry. Pairs with a plain sum above 15 show whether the returned carry lands at bit 0. The sixteen complement pairs are the only inputs on which the policy decides the zero encoding, so they separate force-one from force-zero and expose any mishandling of the reserved codes. The double positive zero and double negative zero pairs show that the policy never overrides a zero that the operands themselves determine. A combinational instance and a registered instance are driven with the same vectors, which checks the one-cycle latency and the reset value.

// File: rtl/oca_pkg.sv
package oca_pkg;

    typedef enum logic [1:0] {
        ZP_FORCE_ONE  = 2'b00,
        ZP_FORCE_ZERO = 2'b01,
        ZP_RSVD_A     = 2'b10,
        ZP_RSVD_B     = 2'b11
    } zpol_e;

endpackage

// File: rtl/oca_pg.sv
// Per-bit propagate/generate and group terms of a+b with carry-in 0.
module oca_pg #(
    parameter int N = 16
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    output logic [N-1:0] p,
    output logic [N-1:0] g,
    output logic         grp_g,
    output logic         grp_p
);
    logic [N:0] cg;

    assign p     = a ^ b;
    assign g     = a & b;
    assign cg[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_grp
        assign cg[i+1] = g[i] | (p[i] & cg[i]);
    end

    assign grp_g = cg[N];
    assign grp_p = &p;
endmodule

// File: rtl/oca_wrap.sv
// Returned carry: taken from group terms only, never from the sum.
module oca_wrap
    import oca_pkg::*;
(
    input  logic  grp_g,
    input  logic  grp_p,
    input  zpol_e pol,
    output logic  cin
);
    always_comb begin
        if (!grp_p) begin
            cin = grp_g;
        end else begin
            unique case (pol)
                ZP_FORCE_ZERO:                      cin = 1'b0;
                ZP_FORCE_ONE, ZP_RSVD_A, ZP_RSVD_B: cin = 1'b1;
                default:                            cin = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/oca_sum.sv
// Carry chain seeded with the returned carry; the final carry out is not needed.
module oca_sum #(
    parameter int N = 16
) (
    input  logic [N-1:0] p,
    input  logic [N-1:0] g,
    input  logic         cin,
    output logic [N-1:0] sum
);
    logic [N-1:0] c;

    assign c[0] = cin;
    for (genvar i = 1; i < N; i++) begin : g_chain
        assign c[i] = g[i-1] | (p[i-1] & c[i-1]);
    end

    assign sum = p ^ c;
endmodule

// File: rtl/oca_adder.sv
module oca_adder
    import oca_pkg::*;
#(
    parameter int N       = 16,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic [1:0]   zpol,
    output logic [N-1:0] sum,
    output logic         is_zero,
    output logic         is_negzero
);
    localparam logic [N-1:0] NEG_ZERO = {N{1'b1}};
    localparam logic [N-1:0] POS_ZERO = '0;

    logic [N-1:0] p, g, sum_c;
    logic         grp_g, grp_p, cin;
    logic         zero_c, neg_c;
    zpol_e        pol;

    assign pol = zpol_e'(zpol);

    oca_pg #(.N(N)) u_pg (
        .a(a), .b(b), .p(p), .g(g), .grp_g(grp_g), .grp_p(grp_p)
    );

    oca_wrap u_wrap (
        .grp_g(grp_g), .grp_p(grp_p), .pol(pol), .cin(cin)
    );

    oca_sum #(.N(N)) u_sum (
        .p(p), .g(g), .cin(cin), .sum(sum_c)
    );

    assign neg_c  = (sum_c == NEG_ZERO);
    assign zero_c = neg_c | (sum_c == POS_ZERO);

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sum        <= POS_ZERO;
                is_zero    <= 1'b1;
                is_negzero <= 1'b0;
            end else begin
                sum        <= sum_c;
                is_zero    <= zero_c;
                is_negzero <= neg_c;
            end
        end
    end else begin : g_comb
        assign sum        = sum_c;
        assign is_zero    = zero_c;
        assign is_negzero = neg_c;
    end
endmodule

// File: rtl/oca_adder_chk.sv
module oca_adder_chk #(
    parameter int N       = 16,
    parameter bit REG_OUT = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] a,
    input logic [N-1:0] b,
    input logic [1:0]   zpol,
    input logic [N-1:0] sum,
    input logic         is_zero,
    input logic         is_negzero
);
    p_zero_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        is_zero == ((sum == '0) || (&sum)));

    p_negzero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        is_negzero == (&sum));

    if (REG_OUT) begin : g_seq
        // R5: reserved codes fold into the force-one case; R9: one-cycle latency
        p_cpair_force_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ((&(a ^ b)) && zpol != 2'b01) |=> (sum == '0));
        p_cpair_force_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ((&(a ^ b)) && zpol == 2'b01) |=> (&sum));
        p_double_negzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ((&a) && (&b)) |=> (&sum));
        p_double_poszero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (a == '0 && b == '0) |=> (sum == '0));
    end else begin : g_cmb
        p_cpair_force_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ((&(a ^ b)) && zpol != 2'b01) |-> (sum == '0));
        p_cpair_force_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ((&(a ^ b)) && zpol == 2'b01) |-> (&sum));
        p_double_negzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ((&a) && (&b)) |-> (&sum));
        p_double_poszero_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (a == '0 && b == '0) |-> (sum == '0));
    end
endmodule

bind oca_adder oca_adder_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .zpol(zpol),
    .sum(sum), .is_zero(is_zero), .is_negzero(is_negzero)
);

// File: tb/oca_adder_bench.sv
module oca_adder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 4;
    localparam int MODV       = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a = '0, b = '0;
    logic [1:0]   zpol = 2'b00;
    logic [W-1:0] sum_r, sum_c;
    logic         z_r, n_r, z_c, n_c;
    int           vectors = 0;
    int           miscompares = 0;
    bit           done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    oca_adder #(.N(W), .REG_OUT(1'b1)) u_oca_adder (
        .clk(clk), .rst_n(rst_n), .a(a), .b(b), .zpol(zpol),
        .sum(sum_r), .is_zero(z_r), .is_negzero(n_r)
    );

    oca_adder #(.N(W), .REG_OUT(1'b0)) u_oca_adder_comb (
        .clk(clk), .rst_n(rst_n), .a(a), .b(b), .zpol(zpol),
        .sum(sum_c), .is_zero(z_c), .is_negzero(n_c)
    );

    function automatic logic [W-1:0] model(int x, int y, int pol);
        int s = x + y;
        if (s == MODV) return (pol == 1) ? {W{1'b1}} : '0;
        if (s > MODV) s = s - MODV;
        return s[W-1:0];
    endfunction

    function automatic string tag(int x, int y, int pol);
        if (x + y == MODV) return (pol == 0) ? "R3" : (pol == 1) ? "R4" : "R5";
        if ((x == 0 && y == 0) || (x == MODV && y == MODV)) return "R6";
        if (x + y > MODV) return "R2";
        return "R1";
    endfunction

    task automatic check(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s a=%0d b=%0d pol=%0d actual=%0d expected=%0d",
                     req, a, b, zpol, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL R9 watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10", sum_r, 0);
        check("R10", z_r, 1);
        check("R10", n_r, 0);
        rst_n = 1'b1;
        for (int pol = 0; pol < 4; pol++) begin
            for (int x = 0; x <= MODV; x++) begin
                for (int y = 0; y <= MODV; y++) begin
                    logic [W-1:0] e;
                    string t;
                    @(negedge clk);
                    a = x[W-1:0]; b = y[W-1:0]; zpol = pol[1:0];
                    e = model(x, y, pol);
                    t = tag(x, y, pol);
                    #1;
                    check(t, sum_c, e);
                    check("R7", z_c, (e == 0 || e == MODV[W-1:0]) ? 1 : 0);
                    check("R8", n_c, (e == MODV[W-1:0]) ? 1 : 0);
                    @(posedge clk);
                    #1;
                    check("R9", sum_r, e);
                    check("R7", z_r, (e == 0 || e == MODV[W-1:0]) ? 1 : 0);
                    check("R8", n_r, (e == MODV[W-1:0]) ? 1 : 0);
                end
            end
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule